// File: doc/BRIEF.md
# Vector memory instruction decoder

This block sits in the decode stage of a core that supports vector memory operations. It decodes 32-bit instructions in the two floating-point load/store major opcodes, which scalar and vector memory operations share. The width field picks the kind of operation. Four of its values mean a scalar floating-point access. Those instructions are flagged so that the normal scalar decoder keeps handling them. The other four values mean a vector access, and the block then breaks the instruction into its fields.

For a vector operation the block reports the following:
- the addressing mode;
- the segment field count;
- the mask enable;
- an encoded element width, and whether that width describes the data or the index;
- the unit-stride sub-operation;
- the three register specifiers.

Reserved encodings raise an illegal-instruction flag. These are a set extended-width bit, an undefined unit-stride sub-select, and fault-only-first on a store. All results are registered, so they appear one clock after the instruction is presented.

Top module: `vmem_decoder`

## Requirements
- R1: While `rstN` is low, and on the first edge after it falls, every output is driven to zero.
- R2: An instruction presented with `instValid` high at a rising edge has its decode on the outputs after that edge, and `outValid` is high. A cycle with `instValid` low gives `outValid`, `vecOp`, `scalarFp` and `illegal` all low.
- R3: Only opcode bits [6:0] equal to 7'b0000111 (load) or 7'b0100111 (store) are claimed. Any other opcode gives `vecOp`, `scalarFp` and `illegal` all low. `isStore` is high for the store opcode.
- R4: In a claimed opcode, width bits [14:12] of 001, 010, 011 or 100 give `scalarFp` high, with `vecOp` low and `illegal` low.
- R5: Width values 000, 101, 110 and 111 give `vecOp` high, with `eewCode` equal to 0, 1, 2 and 3 respectively (8, 16, 32 and 64-bit elements).
- R6: A vector operation with bit 28 set raises `illegal`.
- R7: For a legal vector operation, the fields come from the instruction as follows:
  - `addrMode` is bits [27:26];
  - `nFields` is bits [31:29];
  - `maskEn` is the inverse of bit 25;
  - `vd` is bits [11:7];
  - `rs1` is bits [19:15];
  - `rs2` is bits [24:20].
- R8: `widthIsIndex` is high exactly for legal vector operations whose addressing mode is 01 or 11 (indexed). For modes 00 (unit-stride) and 10 (strided) the width is the data width, and `widthIsIndex` is low.
- R9: With mode 00, bits [24:20] select `usSub`:
  - 00000 gives 0 (plain);
  - 01000 gives 1 (whole register);
  - 01011 gives 2 (mask);
  - 10000 gives 3 (fault-only-first);
  - any other value raises `illegal`.
  Modes other than 00 give `usSub` = 0 and never raise `illegal` from these bits.
- R10: Fault-only-first (mode 00, bits [24:20] = 10000) with the store opcode raises `illegal`. With the load opcode it is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| instValid | input | 1 | Instruction word is valid this cycle |
| instWord | input | 32 | Instruction to decode |
| outValid | output | 1 | Registered decode is valid |
| vecOp | output | 1 | Vector memory operation |
| scalarFp | output | 1 | Scalar floating-point load/store, for the scalar decoder |
| illegal | output | 1 | Reserved vector encoding |
| isStore | output | 1 | Store opcode |
| addrMode | output | 2 | Addressing mode: 00 unit, 10 strided, 01/11 indexed |
| nFields | output | 3 | Segment field count code |
| maskEn | output | 1 | Operation is masked |
| eewCode | output | 2 | Width code: 0=8, 1=16, 2=32, 3=64 bits |
| widthIsIndex | output | 1 | Width describes the index, data width comes from vtype |
| usSub | output | 2 | Unit-stride sub-operation |
| vd | output | 5 | Destination (load) or store-data register |
| rs1 | output | 5 | Base address register |
| rs2 | output | 5 | Stride register, index register or sub-select bits |

## Verification
The assertions assume that `instValid` and `instWord` are stable around the rising edge and that `instValid` is low during reset. The assertions on reserved encodings also assume that the word seen at one edge is the word whose decode appears at the next. The stimulus drives inputs only on falling edges and holds `instValid` low through reset. Random words draw the opcode mostly from the two claimed values. The sub-select bits come mostly from the four defined codes, with a share of arbitrary values so that reserved ones also occur.

// File: rtl/vmd_pkg.sv
package vmd_pkg;
  localparam int INSN_W = 32;
  localparam int REG_W  = 5;
  localparam int NF_W   = 3;

  localparam logic [6:0] OPC_LOAD  = 7'b0000111;
  localparam logic [6:0] OPC_STORE = 7'b0100111;

  typedef enum logic [1:0] {
    US_PLAIN  = 2'd0,
    US_WHOLE  = 2'd1,
    US_MASK   = 2'd2,
    US_FFIRST = 2'd3
  } usSub_e;

  typedef struct packed {
    logic       load;
    logic       isVec;
    logic       isScalar;
    logic       illegal;
    logic       isStore;
    logic [1:0] eewCode;
    logic       isIndex;
    usSub_e     sub;
  } strobe_t;
endpackage

// File: rtl/vmd_ctrl.sv
module vmd_ctrl
  import vmd_pkg::*;
(
  input  logic         instValid,
  input  logic [6:0]   opcode,
  input  logic [2:0]   width,
  input  logic         mew,
  input  logic [1:0]   mop,
  input  logic [REG_W-1:0] subBits,
  output strobe_t      strb
);
  logic   claimed, storeOp, vecWidth, subBad;
  usSub_e subSel;

  always_comb begin
    storeOp  = (opcode == OPC_STORE);
    claimed  = instValid && ((opcode == OPC_LOAD) || storeOp);
    vecWidth = (width == 3'b000) || (width >= 3'b101);

    subSel = US_PLAIN;
    subBad = 1'b0;
    if (mop == 2'b00) begin
      unique case (subBits)
        5'b00000: subSel = US_PLAIN;
        5'b01000: subSel = US_WHOLE;
        5'b01011: subSel = US_MASK;
        5'b10000: begin
          subSel = US_FFIRST;
          subBad = storeOp;
        end
        default:  subBad = 1'b1;
      endcase
    end

    strb          = '0;
    strb.load     = instValid;
    strb.isStore  = claimed && storeOp;
    strb.isScalar = claimed && !vecWidth;
    strb.isVec    = claimed && vecWidth;
    strb.illegal  = claimed && vecWidth && (mew || subBad);
    strb.isIndex  = claimed && vecWidth && !(mew || subBad) && mop[0];
    strb.sub      = subSel;
    unique case (width)
      3'b101:  strb.eewCode = 2'd1;
      3'b110:  strb.eewCode = 2'd2;
      3'b111:  strb.eewCode = 2'd3;
      default: strb.eewCode = 2'd0;
    endcase
  end
endmodule

// File: rtl/vmd_data.sv
module vmd_data
  import vmd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [NF_W-1:0]  nfIn,
  input  logic [1:0]       mopIn,
  input  logic             vmIn,
  input  logic [REG_W-1:0] rs2In,
  input  logic [REG_W-1:0] rs1In,
  input  logic [REG_W-1:0] vdIn,
  output logic             outValid,
  output logic             vecOp,
  output logic             scalarFp,
  output logic             illegal,
  output logic             isStore,
  output logic [1:0]       addrMode,
  output logic [NF_W-1:0]  nFields,
  output logic             maskEn,
  output logic [1:0]       eewCode,
  output logic             widthIsIndex,
  output logic [1:0]       usSub,
  output logic [REG_W-1:0] vd,
  output logic [REG_W-1:0] rs1,
  output logic [REG_W-1:0] rs2
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      vecOp        <= 1'b0;
      scalarFp     <= 1'b0;
      illegal      <= 1'b0;
      isStore      <= 1'b0;
      addrMode     <= '0;
      nFields      <= '0;
      maskEn       <= 1'b0;
      eewCode      <= '0;
      widthIsIndex <= 1'b0;
      usSub        <= '0;
      vd           <= '0;
      rs1          <= '0;
      rs2          <= '0;
    end else begin
      outValid     <= strb.load;
      vecOp        <= strb.isVec;
      scalarFp     <= strb.isScalar;
      illegal      <= strb.illegal;
      isStore      <= strb.isStore;
      addrMode     <= mopIn;
      nFields      <= nfIn;
      maskEn       <= !vmIn;
      eewCode      <= strb.eewCode;
      widthIsIndex <= strb.isIndex;
      usSub        <= strb.sub;
      vd           <= vdIn;
      rs1          <= rs1In;
      rs2          <= rs2In;
    end
  end
endmodule

// File: rtl/vmem_decoder.sv
module vmem_decoder
  import vmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [INSN_W-1:0] instWord,
  output logic              outValid,
  output logic              vecOp,
  output logic              scalarFp,
  output logic              illegal,
  output logic              isStore,
  output logic [1:0]        addrMode,
  output logic [NF_W-1:0]   nFields,
  output logic              maskEn,
  output logic [1:0]        eewCode,
  output logic              widthIsIndex,
  output logic [1:0]        usSub,
  output logic [REG_W-1:0]  vd,
  output logic [REG_W-1:0]  rs1,
  output logic [REG_W-1:0]  rs2
);
  strobe_t strb;

  vmd_ctrl uCtrl (
    .instValid (instValid),
    .opcode    (instWord[6:0]),
    .width     (instWord[14:12]),
    .mew       (instWord[28]),
    .mop       (instWord[27:26]),
    .subBits   (instWord[24:20]),
    .strb      (strb)
  );

  vmd_data uData (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .nfIn         (instWord[31:29]),
    .mopIn        (instWord[27:26]),
    .vmIn         (instWord[25]),
    .rs2In        (instWord[24:20]),
    .rs1In        (instWord[19:15]),
    .vdIn         (instWord[11:7]),
    .outValid     (outValid),
    .vecOp        (vecOp),
    .scalarFp     (scalarFp),
    .illegal      (illegal),
    .isStore      (isStore),
    .addrMode     (addrMode),
    .nFields      (nFields),
    .maskEn       (maskEn),
    .eewCode      (eewCode),
    .widthIsIndex (widthIsIndex),
    .usSub        (usSub),
    .vd           (vd),
    .rs1          (rs1),
    .rs2          (rs2)
  );
endmodule

// File: rtl/vmd_checker.sv
module vmd_checker (
  input logic        clk,
  input logic        rstN,
  input logic        instValid,
  input logic [31:0] instWord,
  input logic        outValid,
  input logic        vecOp,
  input logic        scalarFp,
  input logic        illegal,
  input logic        isStore,
  input logic [1:0]  usSub,
  input logic        widthIsIndex
);
  logic inClaimed, inVecWidth;
  assign inClaimed  = instValid && (instWord[6:0] == 7'b0000111 || instWord[6:0] == 7'b0100111);
  assign inVecWidth = (instWord[14:12] == 3'b000) || (instWord[14:12] >= 3'b101);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    instValid |=> outValid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!vecOp && !scalarFp && !illegal));

  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(vecOp && scalarFp));

  a_r4_scalar_legal: assert property (@(posedge clk) disable iff (!rstN)
    scalarFp |-> !illegal);

  a_r6_mew_illegal: assert property (@(posedge clk) disable iff (!rstN)
    (inClaimed && inVecWidth && instWord[28]) |=> illegal);

  a_r8_index_legal: assert property (@(posedge clk) disable iff (!rstN)
    widthIsIndex |-> (vecOp && !illegal));

  a_r10_no_store_ffirst: assert property (@(posedge clk) disable iff (!rstN)
    (vecOp && isStore && !illegal) |-> (usSub != 2'd3));
endmodule

bind vmem_decoder vmd_checker chk (.*);

// File: tb/tb_vmem_decoder.sv
module tb_vmem_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic        outValid, vecOp, scalarFp, illegal, isStore, maskEn, widthIsIndex;
  logic [1:0]  addrMode, eewCode, usSub;
  logic [2:0]  nFields;
  logic [4:0]  vd, rs1, rs2;

  int nRun = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vmem_decoder dut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .outValid(outValid), .vecOp(vecOp), .scalarFp(scalarFp), .illegal(illegal),
    .isStore(isStore), .addrMode(addrMode), .nFields(nFields), .maskEn(maskEn),
    .eewCode(eewCode), .widthIsIndex(widthIsIndex), .usSub(usSub),
    .vd(vd), .rs1(rs1), .rs2(rs2)
  );

  task automatic chk(input string tag, input int got, input int exp);
    nRun++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d (word %h)", tag, got, exp, instWord);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] opc, input logic [2:0] w,
                                     input logic mew, input logic [1:0] mop,
                                     input logic [4:0] sub, input logic [2:0] nf,
                                     input logic vm, input logic [4:0] r1, input logic [4:0] d);
    return {nf, mew, mop, vm, sub, r1, w, d, opc};
  endfunction

  task automatic runOne(input logic [31:0] w, input logic v);
    logic claimed, st, vw, bad;
    int   eExp, sExp;
    @(negedge clk);
    instValid = v;
    instWord  = w;
    @(negedge clk);
    st      = (w[6:0] == 7'b0100111);
    claimed = v && (w[6:0] == 7'b0000111 || st);
    vw      = (w[14:12] == 3'b000) || (w[14:12] >= 3'b101);
    sExp = 0;
    bad  = w[28];
    if (w[27:26] == 2'b00) begin
      case (w[24:20])
        5'b00000: sExp = 0;
        5'b01000: sExp = 1;
        5'b01011: sExp = 2;
        5'b10000: begin sExp = 3; if (st) bad = 1'b1; end
        default:  bad = 1'b1;
      endcase
    end
    eExp = (w[14:12] == 3'b000) ? 0 : int'(w[14:12]) - 4;
    chk("R2 outValid", int'(outValid), int'(v));
    chk("R3/R5 vecOp", int'(vecOp), int'(claimed && vw));
    chk("R3/R4 scalarFp", int'(scalarFp), int'(claimed && !vw));
    chk("R6/R9/R10 illegal", int'(illegal), int'(claimed && vw && bad));
    if (claimed) chk("R3 isStore", int'(isStore), int'(st));
    if (claimed && vw && !bad) begin
      chk("R5 eewCode", int'(eewCode), eExp);
      chk("R7 addrMode", int'(addrMode), int'(w[27:26]));
      chk("R7 nFields", int'(nFields), int'(w[31:29]));
      chk("R7 maskEn", int'(maskEn), int'(!w[25]));
      chk("R7 vd", int'(vd), int'(w[11:7]));
      chk("R7 rs1", int'(rs1), int'(w[19:15]));
      chk("R7 rs2", int'(rs2), int'(w[24:20]));
      chk("R8 widthIsIndex", int'(widthIsIndex), int'(w[26]));
      chk("R9 usSub", int'(usSub), sExp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [6:0]  opc;
    logic [4:0]  sub;
    int          seed;
    seed = 32'h5eed1234;
    void'($urandom(seed));

    repeat (3) @(negedge clk);
    chk("R1 reset outValid", int'(outValid), 0);
    chk("R1 reset vecOp", int'(vecOp), 0);
    chk("R1 reset fields", int'({addrMode, nFields, eewCode, usSub, vd, rs1, rs2}), 0);
    rstN = 1'b1;

    // directed corners
    runOne(mk(7'b0000111, 3'b010, 0, 2'b00, 5'd0, 3'd0, 1, 5'd3, 5'd4), 1);    // R4 scalar word load
    runOne(mk(7'b0100111, 3'b011, 0, 2'b00, 5'd0, 3'd0, 1, 5'd3, 5'd4), 1);    // R4 scalar double store
    runOne(mk(7'b0000111, 3'b110, 0, 2'b00, 5'd0, 3'd0, 1, 5'd10, 5'd8), 1);   // R5 plain 32-bit load
    runOne(mk(7'b0100111, 3'b000, 0, 2'b00, 5'b10000, 3'd0, 1, 5'd1, 5'd2), 1); // R10 store ffirst
    runOne(mk(7'b0000111, 3'b000, 0, 2'b00, 5'b10000, 3'd0, 0, 5'd1, 5'd2), 1); // R10 load ffirst legal
    runOne(mk(7'b0000111, 3'b111, 1, 2'b10, 5'd7, 3'd0, 1, 5'd1, 5'd2), 1);     // R6 mew set
    runOne(mk(7'b0000111, 3'b101, 0, 2'b00, 5'b00001, 3'd0, 1, 5'd1, 5'd2), 1); // R9 reserved sub
    runOne(mk(7'b0000111, 3'b101, 0, 2'b00, 5'b01000, 3'd7, 1, 5'd1, 5'd2), 1); // R9 whole register
    runOne(mk(7'b0100111, 3'b000, 0, 2'b00, 5'b01011, 3'd0, 1, 5'd1, 5'd2), 1); // R9 mask store
    runOne(mk(7'b0000111, 3'b110, 0, 2'b11, 5'd9, 3'd2, 0, 5'd5, 5'd6), 1);     // R8 ordered indexed
    runOne(mk(7'b0100111, 3'b101, 0, 2'b01, 5'd17, 3'd0, 1, 5'd5, 5'd6), 1);    // R8 unordered indexed
    runOne(mk(7'b0000111, 3'b111, 0, 2'b10, 5'b00001, 3'd1, 0, 5'd5, 5'd6), 1); // R9 strided ignores sub
    runOne(mk(7'b0110011, 3'b000, 0, 2'b00, 5'd0, 3'd0, 1, 5'd5, 5'd6), 1);     // R3 foreign opcode
    runOne(mk(7'b0000111, 3'b000, 0, 2'b00, 5'd0, 3'd0, 1, 5'd5, 5'd6), 0);     // R2 not valid

    for (int i = 0; i < 3000; i++) begin
      case ($urandom_range(0, 4))
        0, 1:    opc = 7'b0000111;
        2, 3:    opc = 7'b0100111;
        default: opc = 7'($urandom);
      endcase
      case ($urandom_range(0, 5))
        0:       sub = 5'b00000;
        1:       sub = 5'b01000;
        2:       sub = 5'b01011;
        3:       sub = 5'b10000;
        default: sub = 5'($urandom);
      endcase
      w = $urandom;
      w[6:0]   = opc;
      w[24:20] = sub;
      w[28]    = ($urandom_range(0, 7) == 0);
      runOne(w, ($urandom_range(0, 9) != 0));
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule